// File: doc/BRIEF.md
# Bundled-Data Four-Phase Pipeline Stage

This block is one stage of a self-timed style pipeline that carries its data on a single-rail bundled bus: one wire per bit, running through an ordinary combinational function. A request runs next to the bus through a matched-delay element. Here that element is modelled as a cycle counter. It produces a delayed completion signal that arrives after the slowest path through the function, so the completion time is always the worst case and does not depend on the data. The placeholder function adds a constant to the input word, modulo the bus width.

Both sides of the stage use a level-sensitive four-phase handshake that returns to zero. The input side pairs `req_in` with `ack_in`, and the output side pairs `req_out` with `ack_out`. A transfer on each side takes four events in this order: the request rises, then the acknowledge rises, then the request falls, then the acknowledge falls. The return-to-zero half of each cycle computes nothing. The stage holds one result word. An upstream sender gets `ack_in` once its word has been transformed and latched. The result is then offered downstream on `data_out` under `req_out`.

Top module: `bd_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ack_in` and `req_out` are 0 and `data_out` is all zeros.
- R2: Each word delivered on `data_out` equals (`data_in` + `STEP`) modulo 2^`DATA_W`. Here `data_in` is the value held while `req_in` was high for that transfer.
- R3: `ack_in` rises exactly `DELAY_CYCLES`+1 clock edges after the edge that first samples `req_in` high, provided the result register is empty. It never rises earlier than that.
- R4: Once `ack_in` is high, it stays high for as long as `req_in` is sampled high. It falls on the first edge that samples `req_in` low.
- R5: After a handshake completes, no new transfer starts until `req_in` is sampled high again. With `req_in` held low, `ack_in` stays low and no further word appears on the output.
- R6: `req_out` rises on the edge after a result is latched, if `ack_out` is low. It then holds, with `data_out` stable, until `ack_out` is sampled high, and it falls on that same edge.
- R7: `req_out` does not rise again while `ack_out` is still high from the previous transfer.
- R8: Under any pattern of stalls on `ack_out` and on `req_in`, every word sent is delivered exactly once and in order.
- R9: While the held result has not been taken downstream, a pending input request is not acknowledged. Its `ack_in` rises only after the held word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Upstream request; the bundled data is valid while high |
| data_in | input | DATA_W | Upstream bundled data word |
| ack_in | output | 1 | Acknowledge to upstream: result latched |
| req_out | output | 1 | Downstream request; `data_out` is valid while high |
| data_out | output | DATA_W | Latched result word |
| ack_out | input | 1 | Acknowledge from downstream |

## Verification
A wrong delay count appears on `ack_in` within the first transfer after reset. It is one or more cycles early or late against the exact `DELAY_CYCLES`+1 edge latency. A corrupted occupancy flag shows up at the next downstream handshake. It appears either as a second `req_out` for the same word, which the consumer sees as a repeated value, or as a missing word, which it sees as a gap in the ascending sequence. Errors in the handshake levels, such as an acknowledge that drops early or a request that returns while `ack_out` is high, are visible on the ports in the same or the next cycle.

// File: rtl/bd_stage_pkg.sv
package bd_stage_pkg;

  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_WAIT = 2'd1,
    IN_ACK  = 2'd2
  } in_state_e;

  // Placeholder function block: add a constant; caller truncates to its width.
  function automatic logic [63:0] stage_op(input logic [63:0] x, input logic [63:0] step);
    return x + step;
  endfunction

endpackage

// File: rtl/bd_match_delay.sv
module bd_match_delay #(
  parameter int DELAY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);

  generate
    if (DELAY_CYCLES == 0) begin : g_none
      assign expired = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (start) begin
          cnt_q <= CW'(DELAY_CYCLES);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      assign expired = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/bd_in_ctrl.sv
module bd_in_ctrl
  import bd_stage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic expired,
  input  logic slot_full,
  output logic start_delay,
  output logic latch_en,
  output logic ack_in
);
  in_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    start_delay = 1'b0;
    latch_en    = 1'b0;
    unique case (state_q)
      IN_IDLE: begin
        if (req_in) begin
          start_delay = 1'b1;
          state_d     = IN_WAIT;
        end
      end
      IN_WAIT: begin
        if (expired && !slot_full) begin
          latch_en = 1'b1;
          state_d  = IN_ACK;
        end
      end
      IN_ACK: begin
        if (!req_in) state_d = IN_IDLE;
      end
      default: state_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= IN_IDLE;
    else        state_q <= state_d;
  end

  assign ack_in = (state_q == IN_ACK);

endmodule

// File: rtl/bd_result_reg.sv
module bd_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic              consume,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
    end else begin
      if (latch_en) begin
        q    <= d;
        full <= 1'b1;
      end else if (consume) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bd_out_ctrl.sv
module bd_out_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic ack_out,
  output logic req_out,
  output logic consume
);
  assign consume = req_out && ack_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_out <= 1'b0;
    end else if (consume) begin
      req_out <= 1'b0;
    end else if (!req_out && full && !ack_out) begin
      req_out <= 1'b1;
    end
  end

endmodule

// File: rtl/bd_stage.sv
module bd_stage
  import bd_stage_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STEP         = 1,
  parameter int DELAY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_in,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out,
  input  logic              ack_out
);
  // Named internal events, visible to the checker
  logic              start_delay;
  logic              delay_done;
  logic              latch_en;
  logic              consume;
  logic              slot_full;
  logic [DATA_W-1:0] fn_result;

  assign fn_result = DATA_W'(stage_op(64'(data_in), 64'(STEP)));

  bd_match_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_delay),
    .expired (delay_done)
  );

  bd_in_ctrl u_in (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_in      (req_in),
    .expired     (delay_done),
    .slot_full   (slot_full),
    .start_delay (start_delay),
    .latch_en    (latch_en),
    .ack_in      (ack_in)
  );

  bd_result_reg #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (latch_en),
    .consume  (consume),
    .d        (fn_result),
    .q        (data_out),
    .full     (slot_full)
  );

  bd_out_ctrl u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .full    (slot_full),
    .ack_out (ack_out),
    .req_out (req_out),
    .consume (consume)
  );

endmodule

// File: rtl/bd_stage_chk.sv
module bd_stage_chk #(
  parameter int DATA_W       = 8,
  parameter int DELAY_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_in,
  input logic              ack_in,
  input logic              req_out,
  input logic              ack_out,
  input logic [DATA_W-1:0] data_out,
  input logic              start_delay,
  input logic              latch_en
);
  localparam int CW  = $clog2(DELAY_CYCLES + 2) + 1;
  localparam int SAT = DELAY_CYCLES + 1;

  logic [CW-1:0] since_start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_start <= '0;
    else if (start_delay)            since_start <= '0;
    else if (since_start != CW'(SAT)) since_start <= since_start + 1'b1;
  end

  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> (since_start >= CW'(DELAY_CYCLES))); // R3
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && req_in) |=> ack_in); // R4
  AST_ACK_FALLS_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_in) |-> !$past(req_in)); // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_in) |-> $past(req_in)); // R5
  AST_NO_START_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_delay |-> !ack_in); // R5
  AST_REQ_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && !ack_out) |=> (req_out && $stable(data_out))); // R6
  AST_REQ_OUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && ack_out) |=> !req_out); // R6
  AST_REQ_OUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> !$past(ack_out)); // R7

endmodule

bind bd_stage bd_stage_chk #(.DATA_W(DATA_W), .DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_in      (req_in),
  .ack_in      (ack_in),
  .req_out     (req_out),
  .ack_out     (ack_out),
  .data_out    (data_out),
  .start_delay (start_delay),
  .latch_en    (latch_en)
);

// File: tb/bd_stage_tb.sv
module bd_stage_tb;
  localparam int W     = 4;
  localparam int STEP  = 3;
  localparam int DLY   = 4;
  localparam int NSEND = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         ack_in;
  logic         req_out;
  logic [W-1:0] data_out;
  logic         ack_out = 1'b0;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  logic sweep_done = 1'b0;

  always #5 clk = ~clk;

  bd_stage #(.DATA_W(W), .STEP(STEP), .DELAY_CYCLES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .data_in(data_in),
    .ack_in(ack_in), .req_out(req_out), .data_out(data_out), .ack_out(ack_out)
  );

  function automatic logic [W-1:0] expect_of(input int v);
    return W'((v + STEP) % (1 << W));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(inout logic [31:0] s, input int m);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return int'(s % 32'(m));
  endfunction

  // Sends one word; returns negedges counted until ack_in is seen high.
  task automatic send(input logic [W-1:0] v, output int lat);
    lat = 0;
    data_in = v;
    req_in  = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack_in);
  endtask

  task automatic finish_send();
    req_in = 1'b0;
    do @(negedge clk); while (ack_in);
  endtask

  task automatic recv_manual(input logic [W-1:0] exp, input string req);
    while (!req_out) @(negedge clk);
    check(data_out == exp, req, int'(data_out), int'(exp));
    ack_out = 1'b1;
    do @(negedge clk); while (req_out);
    ack_out = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int lat;
    logic [31:0] seed_p = 32'h1234_5679;
    logic [31:0] seed_c = 32'h0BAD_F00D;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!ack_in && !req_out && data_out == '0, "R1 during reset", int'({ack_in, req_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ack_in && !req_out && data_out == '0, "R1 after reset", int'({ack_in, req_out, data_out}), 0);

    // R3 exact latency, R6 req_out one cycle after latch, R2 value
    send(4'd7, lat);
    check(lat == DLY + 2, "R3 ack latency", lat, DLY + 2);
    check(!req_out, "R6 req_out not yet", int'(req_out), 0);
    // R4: hold req_in high, ack_in holds
    repeat (3) @(negedge clk);
    check(ack_in, "R4 ack holds while req high", int'(ack_in), 1);
    check(req_out, "R6 req_out after latch", int'(req_out), 1);
    check(data_out == expect_of(7), "R2 value", int'(data_out), int'(expect_of(7)));
    req_in = 1'b0;
    @(negedge clk);
    check(!ack_in, "R4 ack falls one edge after req low", int'(ack_in), 0);
    // R6: held with stable data while ack_out low
    repeat (4) @(negedge clk);
    check(req_out && data_out == expect_of(7), "R6 hold stable", int'(data_out), int'(expect_of(7)));
    ack_out = 1'b1;
    @(negedge clk);
    check(!req_out, "R6 falls on ack_out", int'(req_out), 0);

    // R5: req_in low, no new transfer
    repeat (8) @(negedge clk);
    check(!ack_in && !req_out, "R5 idle stays idle", int'({ack_in, req_out}), 0);

    // R7: ack_out still high; a new word latches but req_out waits
    send(4'd2, lat);
    check(lat == DLY + 2, "R3 latency second word", lat, DLY + 2);
    finish_send();
    repeat (5) @(negedge clk);
    check(!req_out, "R7 no req_out while ack_out high", int'(req_out), 0);

    // R9: slot occupied; new request not acknowledged
    data_in = 4'd9;
    req_in  = 1'b1;
    repeat (DLY + 8) @(negedge clk);
    check(!ack_in, "R9 ack withheld while full", int'(ack_in), 0);
    ack_out = 1'b0;
    recv_manual(expect_of(2), "R2 R7 held word");
    lat = 0;
    while (!ack_in) begin @(negedge clk); lat++; end
    check(lat <= 3, "R9 ack after consume", lat, 3);
    finish_send();
    recv_manual(expect_of(9), "R9 pending word delivered");

    // R8 sweep: all values three times, random stalls both sides
    fork
      begin
        for (int i = 0; i < NSEND; i++) begin
          repeat (rnd(seed_p, 4)) @(negedge clk);
          send(W'(i % (1 << W)), lat);
          check(lat >= DLY + 2, "R3 never early", lat, DLY + 2);
          repeat (rnd(seed_p, 3)) @(negedge clk);
          finish_send();
        end
      end
      begin
        while (rx_cnt < NSEND) begin
          while (!req_out) @(negedge clk);
          repeat (rnd(seed_c, 6)) begin
            @(negedge clk);
            check(req_out, "R6 held during stall", int'(req_out), 1);
          end
          check(data_out == expect_of(rx_cnt % (1 << W)), "R8 R2 order/value",
                int'(data_out), int'(expect_of(rx_cnt % (1 << W))));
          rx_cnt++;
          ack_out = 1'b1;
          do @(negedge clk); while (req_out);
          repeat (rnd(seed_c, 5)) begin
            @(negedge clk);
            check(!req_out, "R7 no req while ack_out high", int'(req_out), 0);
          end
          ack_out = 1'b0;
          @(negedge clk);
        end
      end
    join
    sweep_done = 1'b1;
    repeat (20) @(negedge clk);
    check(rx_cnt == NSEND, "R8 count delivered", rx_cnt, NSEND);
    check(!req_out, "R8 no duplicate after sweep", int'(req_out), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule